// File: doc/BRIEF.md
# JTAG In-System Flash Command Unit

This block is the device-side end of a JTAG connection used to program an on-chip flash. It holds a standard sixteen-state TAP controller and an 8-bit instruction register. Each loaded opcode picks the length of the data register (8, 32 or 64 bits) and the in-system operation that a data scan triggers: identification reads, entering and leaving configuration mode, loading a target address, programming one 64-bit doubleword, writing the option word, setting the security flag, erasing sectors by mask, blank checking and reading back. A host polls an 8-bit status byte whose ready bit stays low while the array is busy.

The array is a behavioural register file of `NSEC` sectors of `WPS` doublewords, both powers of two, together with a 64-bit option word and a security flag. The controller and the array talk over an internal valid/ready request channel. The controller raises valid only in the Update-DR cycle of an accepted command. The array holds ready low for `BUSY_CYC` TCK cycles after it takes a request. A request that meets ready low is dropped and is not retried, so the host must wait for the ready bit before it sends the next command. Everything runs on TCK. `trst_n` is the asynchronous power-on reset, and it also erases the array model.

Top module: `isc_flash_cmd`

## Requirements
- R1: When the TAP is in Test-Logic-Reset, the instruction becomes ID read (0xFE) and configuration mode clears. A 32-bit data scan under 0xFE returns the `IDCODE` parameter, and under 0x4C returns the `MFG_CODE` parameter.
- R2: The data register length is 32 bits for 0xFE and 0x4C, and 64 bits for 0x07, 0x20, 0x22, 0x23, 0x30, 0x50 and 0x60. Every other opcode uses 8 bits. Shifting is LSB first, and TDI enters at the top bit of the selected length, so bits beyond the length return the bits shifted in.
- R3: The status byte is laid out as follows. Bit 7 reads 0, bit 6 is security set, bits 5:4 read 0, bit 3 is configuration mode, bit 2 is ready, and bits 1:0 hold the error code. Every 8-bit-class opcode and every program or erase opcode captures it into the low byte.
- R4: Loading 0x0C sets configuration mode at Update-IR. Loading 0x0F clears it.
- R5: Outside configuration mode, an Update-DR under 0x20, 0x22, 0x23 or 0x30 has no effect and sets error code 2. A capture under 0x07, 0x50 or 0x60 returns zero and sets error code 2.
- R6: Loading an opcode that is not in the instruction set sets error code 1 and has no other effect. Loading 0x13 clears the error code to 0.
- R7: Under 0x11, an 8-bit scan loads the target address and resets the word offset to 0. An accepted program (0x20 or 0x23) to a sector index stores the doubleword at the offset and advances the offset. A capture under 0x50 returns the word at the offset and advances it. The offset wraps within the sector.
- R8: After an accepted program or erase, ready reads 0 for `BUSY_CYC` cycles. A command update made while ready is 0 is dropped without an error.
- R9: A program to address 0x50 writes the option word with bit 63 forced to 1. A capture under 0x07 returns the option word.
- R10: Option bit i protects sector i. A program to a protected sector is refused with error code 3, and an erase skips that sector.
- R11: Under 0x30, each set bit i of the 64-bit mask erases sector i to all ones.
- R12: A capture under 0x60 returns a vector in which bit i is 1 when some word of sector i is not all ones.
- R13: Opcode 0x22, or a program to address 0x80, sets the security bit. A program to an address that is neither a sector index, 0x50 nor 0x80 sets error code 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; all logic runs on its rising edge |
| trst_n | input | 1 | Asynchronous active-low power-on reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, LSB of the IR or DR shifter |

## Verification
The assertions assume that `trst_n` is pulsed low once before any TMS activity. They also assume that a command reaches the array only through a complete Update-DR, and that a program never reaches the array while the target sector's protection bit is set. The stimulus moves the TAP only through legal TMS paths and always returns to Run-Test/Idle between scans. It waits `BUSY_CYC` idle cycles after each accepted command, except in one deliberate back-to-back update that exercises the drop rule. The array is swept in full, word by word, and the bench computes each expected pattern from the sector and word index.

// File: rtl/isc_pkg.sv
package isc_pkg;
  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PA_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PA_IR, EX2_IR, UPD_IR
  } tap_st_e;

  localparam logic [7:0] OP_IDCODE = 8'hFE;
  localparam logic [7:0] OP_MFG    = 8'h4C;
  localparam logic [7:0] OP_CFG    = 8'h07;
  localparam logic [7:0] OP_EN     = 8'h0C;
  localparam logic [7:0] OP_DIS    = 8'h0F;
  localparam logic [7:0] OP_NOP    = 8'h10;
  localparam logic [7:0] OP_ADDR   = 8'h11;
  localparam logic [7:0] OP_CLR    = 8'h13;
  localparam logic [7:0] OP_PROG   = 8'h20;
  localparam logic [7:0] OP_PSEC   = 8'h22;
  localparam logic [7:0] OP_PUC    = 8'h23;
  localparam logic [7:0] OP_ERASE  = 8'h30;
  localparam logic [7:0] OP_READ   = 8'h50;
  localparam logic [7:0] OP_BLANK  = 8'h60;

  localparam logic [7:0] ADDR_OPT = 8'h50;
  localparam logic [7:0] ADDR_SEC = 8'h80;

  typedef enum logic [1:0] {ERR_NONE = 2'd0, ERR_OPC = 2'd1, ERR_MODE = 2'd2, ERR_TGT = 2'd3} err_e;
  typedef enum logic [1:0] {FOP_PROG, FOP_OPT, FOP_SEC, FOP_ERASE} fop_e;

  function automatic int isc_dr_len(logic [7:0] op);
    case (op)
      OP_IDCODE, OP_MFG: return 32;
      OP_CFG, OP_PROG, OP_PSEC, OP_PUC, OP_ERASE, OP_READ, OP_BLANK: return 64;
      default: return 8;
    endcase
  endfunction

  function automatic logic isc_known(logic [7:0] op);
    case (op)
      OP_IDCODE, OP_MFG, OP_CFG, OP_EN, OP_DIS, OP_NOP, OP_ADDR, OP_CLR,
      OP_PROG, OP_PSEC, OP_PUC, OP_ERASE, OP_READ, OP_BLANK: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // captures that need configuration mode
  function automatic logic isc_cap_gated(logic [7:0] op);
    return (op == OP_CFG) || (op == OP_READ) || (op == OP_BLANK);
  endfunction

  // updates that need configuration mode
  function automatic logic isc_upd_gated(logic [7:0] op);
    return (op == OP_PROG) || (op == OP_PSEC) || (op == OP_PUC) || (op == OP_ERASE);
  endfunction
endpackage

// File: rtl/isc_tap_fsm.sv
module isc_tap_fsm
  import isc_pkg::*;
(
  input  logic    tck,
  input  logic    trst_n,
  input  logic    tms,
  output tap_st_e st
);
  tap_st_e nxt;

  always_comb begin
    case (st)
      TLR:     nxt = tms ? TLR    : RTI;
      RTI:     nxt = tms ? SEL_DR : RTI;
      SEL_DR:  nxt = tms ? SEL_IR : CAP_DR;
      CAP_DR:  nxt = tms ? EX1_DR : SH_DR;
      SH_DR:   nxt = tms ? EX1_DR : SH_DR;
      EX1_DR:  nxt = tms ? UPD_DR : PA_DR;
      PA_DR:   nxt = tms ? EX2_DR : PA_DR;
      EX2_DR:  nxt = tms ? UPD_DR : SH_DR;
      UPD_DR:  nxt = tms ? SEL_DR : RTI;
      SEL_IR:  nxt = tms ? TLR    : CAP_IR;
      CAP_IR:  nxt = tms ? EX1_IR : SH_IR;
      SH_IR:   nxt = tms ? EX1_IR : SH_IR;
      EX1_IR:  nxt = tms ? UPD_IR : PA_IR;
      PA_IR:   nxt = tms ? EX2_IR : PA_IR;
      EX2_IR:  nxt = tms ? UPD_IR : SH_IR;
      default: nxt = tms ? SEL_DR : RTI;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) st <= TLR;
    else         st <= nxt;
endmodule

// File: rtl/isc_shifter.sv
module isc_shifter
  import isc_pkg::*;
#(
  parameter int IRW = 8,
  parameter int DRW = 64,
  localparam int LW = $clog2(DRW + 1)
) (
  input  logic           tck,
  input  logic           trst_n,
  input  tap_st_e        st,
  input  logic           tdi,
  input  logic [IRW-1:0] ir_cap,
  input  logic [DRW-1:0] dr_cap,
  input  logic [LW-1:0]  dr_len,
  output logic [IRW-1:0] ir_sr,
  output logic [DRW-1:0] dr_sr,
  output logic           tdo
);
  logic [DRW-1:0] dr_nxt;

  // TDI enters at the top bit of the selected length
  always_comb begin
    dr_nxt = dr_sr >> 1;
    for (int i = 0; i < DRW; i++)
      if (LW'(i) == dr_len - LW'(1)) dr_nxt[i] = tdi;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr <= '0;
      dr_sr <= '0;
    end else begin
      if (st == CAP_IR)     ir_sr <= ir_cap;
      else if (st == SH_IR) ir_sr <= {tdi, ir_sr[IRW-1:1]};
      if (st == CAP_DR)     dr_sr <= dr_cap;
      else if (st == SH_DR) dr_sr <= dr_nxt;
    end
  end

  assign tdo = (st == SH_IR) ? ir_sr[0] : dr_sr[0];
endmodule

// File: rtl/isc_flash_model.sv
module isc_flash_model
  import isc_pkg::*;
#(
  parameter int NSEC     = 4,
  parameter int WPS      = 4,
  parameter int BUSY_CYC = 100,
  localparam int SW = (NSEC > 1) ? $clog2(NSEC) : 1,
  localparam int WW = (WPS > 1) ? $clog2(WPS) : 1,
  localparam int CW = $clog2(BUSY_CYC + 1)
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  fop_e            req_op,
  input  logic [SW-1:0]   req_sec,
  input  logic [WW-1:0]   req_woff,
  input  logic [63:0]     req_data,
  input  logic [SW-1:0]   rd_sec,
  input  logic [WW-1:0]   rd_woff,
  output logic [63:0]     rd_data,
  output logic [63:0]     opt_word,
  output logic [NSEC-1:0] nonblank,
  output logic            sec_set
);
  logic [63:0]   mem [NSEC*WPS];
  logic [CW-1:0] cnt;
  logic [63:0]   opt_q;
  logic          sec_q;

  assign req_ready = (cnt == '0);
  assign rd_data   = mem[{rd_sec, rd_woff}];
  assign opt_word  = opt_q;
  assign sec_set   = sec_q;

  always_comb begin
    nonblank = '0;
    for (int s = 0; s < NSEC; s++)
      for (int w = 0; w < WPS; w++)
        if (mem[s*WPS+w] != '1) nonblank[s] = 1'b1;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      cnt   <= '0;
      opt_q <= '0;
      sec_q <= 1'b0;
      for (int i = 0; i < NSEC*WPS; i++) mem[i] <= '1;
    end else begin
      if (cnt != '0) cnt <= cnt - 1'b1;
      if (req_valid && req_ready) begin
        cnt <= CW'(BUSY_CYC);
        case (req_op)
          FOP_PROG:  mem[{req_sec, req_woff}] <= req_data;
          FOP_OPT:   opt_q <= req_data | {1'b1, 63'b0};
          FOP_SEC:   sec_q <= 1'b1;
          default:
            for (int s = 0; s < NSEC; s++)
              if (req_data[s] && !opt_q[s])
                for (int w = 0; w < WPS; w++) mem[s*WPS+w] <= '1;
        endcase
      end
    end
  end

  // R8
  busy_after_accept_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R10
  no_protected_write_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (req_valid && req_ready && req_op == FOP_PROG) |-> !opt_q[req_sec]);
endmodule

// File: rtl/isc_flash_cmd.sv
module isc_flash_cmd
  import isc_pkg::*;
#(
  parameter int          NSEC     = 4,
  parameter int          WPS      = 4,
  parameter int          BUSY_CYC = 100,
  parameter logic [31:0] IDCODE   = 32'h4A3C_9E11,
  parameter logic [31:0] MFG_CODE = 32'h0000_0B17
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  output logic tdo
);
  localparam int SW  = (NSEC > 1) ? $clog2(NSEC) : 1;
  localparam int WW  = (WPS > 1) ? $clog2(WPS) : 1;
  localparam int DRW = 64;
  localparam int LW  = $clog2(DRW + 1);

  tap_st_e        tap_st;
  logic [7:0]     ir_sr, ir_q, addr_q;
  logic [DRW-1:0] dr_sr, dr_cap;
  logic [LW-1:0]  dr_len;
  logic           mode_q, tgt_ok;
  err_e           err_q;
  logic [WW-1:0]  woff_q;
  logic [7:0]     status;

  logic            req_valid, req_ready, sec_set;
  fop_e            req_op;
  logic [63:0]     rd_data, opt_word;
  logic [NSEC-1:0] nonblank;

  isc_tap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .st(tap_st));

  isc_shifter #(.IRW(8), .DRW(DRW)) u_shift (
    .tck(tck), .trst_n(trst_n), .st(tap_st), .tdi(tdi),
    .ir_cap(8'h01), .dr_cap(dr_cap), .dr_len(dr_len),
    .ir_sr(ir_sr), .dr_sr(dr_sr), .tdo(tdo)
  );

  isc_flash_model #(.NSEC(NSEC), .WPS(WPS), .BUSY_CYC(BUSY_CYC)) u_array (
    .tck(tck), .trst_n(trst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_sec(addr_q[SW-1:0]), .req_woff(woff_q), .req_data(dr_sr),
    .rd_sec(addr_q[SW-1:0]), .rd_woff(woff_q), .rd_data(rd_data),
    .opt_word(opt_word), .nonblank(nonblank), .sec_set(sec_set)
  );

  assign status = {1'b0, sec_set, 2'b00, mode_q, req_ready, err_q};
  assign dr_len = LW'(isc_dr_len(ir_q));

  always_comb begin
    case (ir_q)
      OP_IDCODE: dr_cap = 64'(IDCODE);
      OP_MFG:    dr_cap = 64'(MFG_CODE);
      OP_CFG:    dr_cap = mode_q ? opt_word : '0;
      OP_READ:   dr_cap = mode_q ? rd_data : '0;
      OP_BLANK:  dr_cap = mode_q ? 64'(nonblank) : '0;
      default:   dr_cap = 64'(status);
    endcase
  end

  // command decode toward the array
  always_comb begin
    req_op = FOP_PROG;
    tgt_ok = 1'b0;
    case (ir_q)
      OP_PROG, OP_PUC: begin
        if (addr_q == ADDR_OPT) begin
          req_op = FOP_OPT;
          tgt_ok = 1'b1;
        end else if (addr_q == ADDR_SEC) begin
          req_op = FOP_SEC;
          tgt_ok = 1'b1;
        end else if (addr_q < 8'(NSEC)) begin
          tgt_ok = !opt_word[addr_q[SW-1:0]];
        end
      end
      OP_PSEC: begin
        req_op = FOP_SEC;
        tgt_ok = 1'b1;
      end
      OP_ERASE: begin
        req_op = FOP_ERASE;
        tgt_ok = 1'b1;
      end
      default: ;
    endcase
  end

  assign req_valid = (tap_st == UPD_DR) && mode_q && tgt_ok;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_q   <= OP_IDCODE;
      mode_q <= 1'b0;
      err_q  <= ERR_NONE;
      addr_q <= '0;
      woff_q <= '0;
    end else begin
      case (tap_st)
        TLR: begin
          ir_q   <= OP_IDCODE;
          mode_q <= 1'b0;
        end
        UPD_IR: begin
          ir_q <= ir_sr;
          if (ir_sr == OP_EN)        mode_q <= 1'b1;
          else if (ir_sr == OP_DIS)  mode_q <= 1'b0;
          else if (ir_sr == OP_CLR)  err_q  <= ERR_NONE;
          else if (!isc_known(ir_sr)) err_q <= ERR_OPC;
        end
        CAP_DR: begin
          if (isc_cap_gated(ir_q)) begin
            if (!mode_q)              err_q  <= ERR_MODE;
            else if (ir_q == OP_READ) woff_q <= woff_q + 1'b1;
          end
        end
        UPD_DR: begin
          if (ir_q == OP_ADDR) begin
            addr_q <= dr_sr[7:0];
            woff_q <= '0;
          end else if (isc_upd_gated(ir_q)) begin
            if (!mode_q)      err_q <= ERR_MODE;
            else if (!tgt_ok) err_q <= ERR_TGT;
            else if (req_ready && req_op == FOP_PROG) woff_q <= woff_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R1
  tlr_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (tap_st == TLR) |=> (ir_q == OP_IDCODE && !mode_q));

  // R6
  bad_opcode_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (tap_st == UPD_IR && !isc_known(ir_sr)) |=> (err_q == ERR_OPC));

  // R7
  offset_advance_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (req_valid && req_ready && req_op == FOP_PROG) |=> (woff_q == $past(woff_q) + WW'(1)));
endmodule

// File: tb/test_isc_flash_cmd.sv
module test_isc_flash_cmd;
  import isc_pkg::*;

  localparam int          NSEC = 4;
  localparam int          WPS  = 4;
  localparam int          BUSY = 100;
  localparam logic [31:0] IDC  = 32'h4A3C_9E11;
  localparam logic [31:0] MFGC = 32'h0000_0B17;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;

  always #4 tck = ~tck;

  isc_flash_cmd #(.NSEC(NSEC), .WPS(WPS), .BUSY_CYC(BUSY), .IDCODE(IDC), .MFG_CODE(MFGC))
    i_isc_flash_cmd (.tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo));

  function automatic logic [63:0] pat(int s, int w);
    return {8'(s), 8'(w), 48'h5A5A_C3C3_0F0F};
  endfunction

  task automatic chk(string rq, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o);
    @(negedge tck);
    o   = tdo;
    tms = m;
    tdi = d;
  endtask

  task automatic idle(input int n);
    logic o;
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, o);
  endtask

  task automatic ir_load(input logic [7:0] op);
    logic o;
    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < 8; i++) step(i == 7, op[i], o);
    step(1, 0, o); step(0, 0, o);
  endtask

  task automatic dr_scan(input int n, input logic [127:0] din, output logic [127:0] dout);
    logic o;
    dout = '0;
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], o);
      dout[i] = o;
    end
    step(1, 0, o); step(0, 0, o);
  endtask

  task automatic get_status(output logic [7:0] s);
    logic [127:0] d;
    ir_load(OP_NOP);
    dr_scan(8, '0, d);
    s = d[7:0];
  endtask

  task automatic set_addr(input logic [7:0] a);
    logic [127:0] d;
    ir_load(OP_ADDR);
    dr_scan(8, 128'(a), d);
  endtask

  initial begin
    repeat (200000) @(posedge tck);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [127:0] d;
    logic [7:0]   s;
    logic o;
    repeat (3) @(negedge tck);
    trst_n = 1'b1;
    step(0, 0, o);

    // R1: reset state selects ID read
    dr_scan(32, '0, d);
    chk("R1 idcode after reset", d[31:0], IDC);
    // R2: 32-bit length; extra bits return what was shifted in
    ir_load(OP_MFG);
    dr_scan(40, 128'hA7, d);
    chk("R1 manufacturer code", d[31:0], MFGC);
    chk("R2 32-bit register length", d[39:32], 8'hA7);
    // R3: idle status
    get_status(s);
    chk("R3 idle status", s, 8'h04);
    ir_load(OP_NOP);
    dr_scan(16, 128'h3C, d);
    chk("R2 8-bit register length", d[15:0], 16'h3C04);

    // R5: gated commands outside mode
    ir_load(OP_PROG);
    dr_scan(64, 128'h1234, d);
    chk("R3 status in program capture", d[7:0], 8'h04);
    ir_load(OP_CFG);
    dr_scan(64, '0, d);
    chk("R5 config read outside mode", d[63:0], 64'h0);
    get_status(s);
    chk("R5 mode error code", s, 8'h06);
    // R6
    ir_load(OP_CLR);
    dr_scan(8, '0, d);
    chk("R6 clear status", d[7:0], 8'h04);
    ir_load(8'h55);
    dr_scan(8, '0, d);
    chk("R6 unknown opcode error", d[7:0], 8'h05);
    ir_load(OP_CLR);
    // R4
    ir_load(OP_EN);
    dr_scan(8, '0, d);
    chk("R4 enable sets mode", d[7:0], 8'h0C);

    // R7/R8: fill every word of every sector
    for (int sc = 0; sc < NSEC; sc++) begin
      set_addr(8'(sc));
      for (int w = 0; w < WPS; w++) begin
        ir_load(OP_PROG);
        dr_scan(64, 128'(pat(sc, w)), d);
        get_status(s);
        chk("R8 ready low while busy", s, 8'h08);
        idle(BUSY);
        get_status(s);
        chk("R8 ready after busy", s, 8'h0C);
      end
    end
    for (int sc = 0; sc < NSEC; sc++) begin
      set_addr(8'(sc));
      ir_load(OP_READ);
      for (int w = 0; w < WPS; w++) begin
        dr_scan(64, '0, d);
        chk("R7 sequential readback", d[63:0], pat(sc, w));
      end
      dr_scan(64, '0, d);
      chk("R7 offset wraps in sector", d[63:0], pat(sc, 0));
    end

    // R8: back-to-back update is dropped
    set_addr(8'd2);
    ir_load(OP_PROG);
    dr_scan(64, 128'h1111_2222_3333_4444, d);
    dr_scan(64, 128'h5555_6666_7777_8888, d);
    idle(BUSY);
    get_status(s);
    chk("R8 drop sets no error", s, 8'h0C);
    set_addr(8'd2);
    ir_load(OP_READ);
    dr_scan(64, '0, d);
    chk("R8 first update stored", d[63:0], 64'h1111_2222_3333_4444);
    dr_scan(64, '0, d);
    chk("R8 second update dropped", d[63:0], pat(2, 1));

    // R9: option word, sector 1 protected
    set_addr(8'h50);
    ir_load(OP_PROG);
    dr_scan(64, 128'h000A_0000_0000_0002, d);
    idle(BUSY);
    ir_load(OP_CFG);
    dr_scan(64, '0, d);
    chk("R9 option word bit 63 forced", d[63:0], 64'h800A_0000_0000_0002);

    // R10: program to protected sector refused
    set_addr(8'd1);
    ir_load(OP_PROG);
    dr_scan(64, '0, d);
    get_status(s);
    chk("R10 protected program error", s, 8'h0F);
    ir_load(OP_CLR);
    set_addr(8'd1);
    ir_load(OP_READ);
    dr_scan(64, '0, d);
    chk("R10 protected word unchanged", d[63:0], pat(1, 0));

    // R11: erase sectors 0 and 1 (1 is protected)
    ir_load(OP_ERASE);
    dr_scan(64, 128'h3, d);
    get_status(s);
    chk("R11 erase busy", s, 8'h08);
    idle(BUSY);
    set_addr(8'd0);
    ir_load(OP_READ);
    dr_scan(64, '0, d);
    chk("R11 sector erased", d[63:0], 64'hFFFF_FFFF_FFFF_FFFF);
    set_addr(8'd1);
    ir_load(OP_READ);
    dr_scan(64, '0, d);
    chk("R10 protected sector kept by erase", d[63:0], pat(1, 0));
    // R12
    ir_load(OP_BLANK);
    dr_scan(64, '0, d);
    chk("R12 blank check vector", d[63:0], 64'hE);

    // R13
    set_addr(8'h90);
    ir_load(OP_PROG);
    dr_scan(64, '0, d);
    get_status(s);
    chk("R13 bad address error", s, 8'h0F);
    ir_load(OP_CLR);
    ir_load(OP_PSEC);
    dr_scan(64, '0, d);
    idle(BUSY);
    get_status(s);
    chk("R13 security bit set", s, 8'h4C);

    // R4: disable
    ir_load(OP_DIS);
    dr_scan(8, '0, d);
    chk("R4 disable clears mode", d[7:0], 8'h44);
    ir_load(OP_EN);
    // R1: Test-Logic-Reset
    for (int i = 0; i < 5; i++) step(1, 0, o);
    step(0, 0, o);
    dr_scan(32, '0, d);
    chk("R1 idcode after TLR", d[31:0], IDC);
    get_status(s);
    chk("R1 mode cleared by TLR", s, 8'h44);

    // R5: erase outside mode has no effect
    ir_load(OP_ERASE);
    dr_scan(64, 128'hF, d);
    get_status(s);
    chk("R5 erase outside mode error", s, 8'h46);
    ir_load(OP_CLR);
    ir_load(OP_EN);
    ir_load(OP_BLANK);
    dr_scan(64, '0, d);
    chk("R5 erase outside mode ignored", d[63:0], 64'hE);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule